// File: doc/BRIEF.md
# Vector Load/Store Address Generator

This block turns one scalar load or store into a sequence of 64-bit effective addresses, one for each vector element. A start pulse captures the operands: the addressing mode, a 64-bit base, a 16-bit signed immediate, the access-width code, the element-width code, an extension-signedness bit, an operand-role bit for indexed mode, a scalar offset and the vector length. The block then counts the element index from zero up to the vector length minus one. It presents each address on a valid/ready output and moves to the next element only when that address is accepted.

There are three addressing modes. In element-strided mode the signed immediate is the stride. In unit-strided mode the immediate is a fixed displacement and the stride is the access width in bytes. In indexed mode a second valid/ready stream supplies one 64-bit element for each index, in order. That element is the offset added to the scalar base. When the operand-role bit is set, the element is instead a full-width base, and the scalar offset is added to it. Whichever operand is the offset is first cut to the element width and then widened again as signed or unsigned. The base is never cut.

Top module: `vls_addr_gen`

## Requirements
- R1: After reset, `addr_valid_o`, `done_o` and `off_ready_o` are low.
- R2: With mode code 1 (element-strided), element i has address base + sext16(imm) × i.
- R3: With mode code 0 (unit-strided), element i has address base + sext16(imm) + B × i, where B = 1, 2, 4 or 8 bytes for access-width codes 0, 1, 2 and 3.
- R4: With mode code 2 (indexed) and `idx_vbase_i` low, element i has address base + X(off_i). off_i is the i-th accepted stream element, and X narrows its argument to the element width and widens it back to 64 bits.
- R5: With mode code 2 and `idx_vbase_i` high, element i has address off_i + X(scalar offset). The stream element is used at its full 64 bits.
- R6: X keeps the low 8, 16, 32 or 64 bits for element-width codes 0, 1, 2 and 3. It then sign-extends them when `idx_signed_i` is high and zero-extends them when it is low.
- R7: While `addr_valid_o` is high and `addr_ready_i` is low, `addr_valid_o` stays high and `addr_o` stays unchanged on the next cycle.
- R8: Exactly VL addresses are produced, one for each output handshake, in ascending element order. `done_o` rises after the last one is accepted, and `addr_valid_o` is low whenever `done_o` is high.
- R9: A start with VL = 0 produces no address and raises `done_o` on the next cycle.
- R10: All address sums and products wrap modulo 2^64.
- R11: A stream element is consumed only on an `off_valid_i`/`off_ready_o` handshake. In indexed mode no address is produced before its element has been consumed. `off_ready_o` stays low in the strided modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse that captures the operands and restarts the index |
| mode_i | input | 2 | 0 unit-strided, 1 element-strided, 2 indexed |
| base_i | input | 64 | Scalar base address |
| imm_i | input | 16 | Signed immediate |
| opw_i | input | 2 | Access-width code (1/2/4/8 bytes) |
| ew_i | input | 2 | Element-width code (8/16/32/64 bits) |
| idx_signed_i | input | 1 | Sign-extend (1) or zero-extend (0) the narrowed offset |
| idx_vbase_i | input | 1 | Indexed: stream carries the base (1) or the offset (0) |
| soff_i | input | 64 | Scalar offset used when the stream carries the base |
| vl_i | input | 8 | Vector length |
| off_valid_i | input | 1 | Stream element valid |
| off_data_i | input | 64 | Stream element |
| off_ready_o | output | 1 | Stream element accepted this cycle when valid |
| addr_valid_o | output | 1 | Address valid |
| addr_ready_i | input | 1 | Address accepted when valid |
| addr_o | output | 64 | Effective address |
| done_o | output | 1 | All addresses of the current operation accepted |

## Verification
Counting from the clock edge that samples `start_i`, the first address is registered on the second edge. Each later address is registered on the edge of the previous handshake, provided its stream element is also offered on that edge in indexed mode. `done_o` rises on the edge of the last handshake, or on the first edge when VL = 0. None of these latencies is fixed once stalls occur, so the expected addresses are queued in element order and compared only at handshakes. All inputs are driven and all outputs read at the falling edge, after combinational settling. The stall check compares the address held during a refused cycle with the address at the next falling edge.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [1:0] {
    AM_UNIT = 2'd0,
    AM_ELEM = 2'd1,
    AM_IDX  = 2'd2
  } amode_e;
endpackage

// File: rtl/vls_ext.sv
// Narrows a value to the element width and widens it back to AW bits.
module vls_ext #(
  parameter int AW = 64
) (
  input  logic [AW-1:0] val_i,
  input  logic [1:0]    ew_i,
  input  logic          sgn_i,
  output logic [AW-1:0] ext_o
);
  localparam int NW = 4;
  logic [AW-1:0] cand [NW];

  for (genvar k = 0; k < NW; k++) begin : g_w
    localparam int W = 8 << k;
    if (W < AW) begin : g_n
      assign cand[k] = {{(AW-W){sgn_i & val_i[W-1]}}, val_i[W-1:0]};
    end else begin : g_f
      assign cand[k] = val_i;
    end
  end

  assign ext_o = cand[ew_i];
endmodule

// File: rtl/vls_stride.sv
// First address and per-element step of the strided modes.
module vls_stride
  import vls_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IMM_W = 16
) (
  input  amode_e           mode_i,
  input  logic [AW-1:0]    base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       opw_i,
  output logic [AW-1:0]    first_o,
  output logic [AW-1:0]    step_o
);
  logic [AW-1:0] imm_x;
  logic [AW-1:0] bytes;

  assign imm_x = {{(AW-IMM_W){imm_i[IMM_W-1]}}, imm_i};
  assign bytes = AW'(1) << opw_i;

  always_comb begin
    if (mode_i == AM_UNIT) begin
      first_o = base_i + imm_x;
      step_o  = bytes;
    end else begin
      first_o = base_i;
      step_o  = imm_x;
    end
  end
endmodule

// File: rtl/vls_seq.sv
// Element counter and completion flag.
module vls_seq #(
  parameter int VLW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [VLW-1:0] vl_i,
  input  logic           load_i,
  input  logic           hs_i,
  output logic           more_o,
  output logic           done_o
);
  logic [VLW-1:0] vl_q;
  logic [VLW-1:0] cnt_q;

  assign more_o = (cnt_q != vl_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      vl_q   <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else if (start_i) begin
      vl_q   <= vl_i;
      cnt_q  <= '0;
      done_o <= (vl_i == '0);
    end else begin
      if (load_i) cnt_q <= cnt_q + VLW'(1);
      if (hs_i && !load_i && !more_o && vl_q != '0) done_o <= 1'b1;
    end
  end

  a_r9_zero_vl: assert property (@(posedge clk) disable iff (rst)
    (start_i && vl_i == '0) |=> (done_o && !more_o));

  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= vl_q);
endmodule

// File: rtl/vls_addr_gen.sv
module vls_addr_gen
  import vls_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IMM_W = 16,
  parameter int VLW   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [AW-1:0]    base_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic [1:0]       opw_i,
  input  logic [1:0]       ew_i,
  input  logic             idx_signed_i,
  input  logic             idx_vbase_i,
  input  logic [AW-1:0]    soff_i,
  input  logic [VLW-1:0]   vl_i,
  input  logic             off_valid_i,
  input  logic [AW-1:0]    off_data_i,
  output logic             off_ready_o,
  output logic             addr_valid_o,
  input  logic             addr_ready_i,
  output logic [AW-1:0]    addr_o,
  output logic             done_o
);
  amode_e        mode_q;
  logic [AW-1:0] base_q, soff_q, acc_q, step_q;
  logic [1:0]    ew_q;
  logic          sgn_q, vbase_q;

  logic [AW-1:0] first_w, step_w, ext_in, ext_out, idx_other, idx_addr;
  logic          more, out_free, load_ok, load, hs;

  vls_stride #(.AW(AW), .IMM_W(IMM_W)) u_stride (
    .mode_i (amode_e'(mode_i)),
    .base_i (base_i),
    .imm_i  (imm_i),
    .opw_i  (opw_i),
    .first_o(first_w),
    .step_o (step_w)
  );

  // The narrowed operand is the stream element unless it carries the base.
  assign ext_in    = vbase_q ? soff_q : off_data_i;
  assign idx_other = vbase_q ? off_data_i : base_q;

  vls_ext #(.AW(AW)) u_ext (
    .val_i(ext_in),
    .ew_i (ew_q),
    .sgn_i(sgn_q),
    .ext_o(ext_out)
  );

  assign idx_addr = idx_other + ext_out;

  assign hs          = addr_valid_o && addr_ready_i;
  assign out_free    = !addr_valid_o || addr_ready_i;
  assign load_ok     = (mode_q != AM_IDX) || off_valid_i;
  assign load        = !start_i && more && out_free && load_ok;
  assign off_ready_o = !start_i && more && out_free && (mode_q == AM_IDX);

  vls_seq #(.VLW(VLW)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .start_i(start_i),
    .vl_i   (vl_i),
    .load_i (load),
    .hs_i   (hs),
    .more_o (more),
    .done_o (done_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q       <= AM_UNIT;
      base_q       <= '0;
      soff_q       <= '0;
      acc_q        <= '0;
      step_q       <= '0;
      ew_q         <= '0;
      sgn_q        <= 1'b0;
      vbase_q      <= 1'b0;
      addr_o       <= '0;
      addr_valid_o <= 1'b0;
    end else if (start_i) begin
      mode_q       <= amode_e'(mode_i);
      base_q       <= base_i;
      soff_q       <= soff_i;
      acc_q        <= first_w;
      step_q       <= step_w;
      ew_q         <= ew_i;
      sgn_q        <= idx_signed_i;
      vbase_q      <= idx_vbase_i;
      addr_valid_o <= 1'b0;
    end else if (load) begin
      addr_o       <= (mode_q == AM_IDX) ? idx_addr : acc_q;
      acc_q        <= acc_q + step_q;
      addr_valid_o <= 1'b1;
    end else if (hs) begin
      addr_valid_o <= 1'b0;
    end
  end

  a_r7_hold_addr: assert property (@(posedge clk) disable iff (rst)
    (addr_valid_o && !addr_ready_i && !start_i) |=> (addr_valid_o && $stable(addr_o)));

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !addr_valid_o);

  a_r11_idx_needs_elem: assert property (@(posedge clk) disable iff (rst)
    ($rose(addr_valid_o) && mode_q == AM_IDX) |-> $past(off_valid_i && off_ready_o));
endmodule

// File: tb/vls_addr_gen_tb.sv
`timescale 1ns/1ps
module vls_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [63:0] base = '0;
  logic [15:0] imm = '0;
  logic [1:0]  opw = '0;
  logic [1:0]  ew = '0;
  logic        sgn = 1'b0;
  logic        vbase = 1'b0;
  logic [63:0] soff = '0;
  logic [7:0]  vl = '0;
  logic        off_valid = 1'b0;
  logic [63:0] off_data = '0;
  logic        off_ready;
  logic        addr_valid;
  logic        addr_ready = 1'b0;
  logic [63:0] addr;
  logic        done;

  always #5 clk = ~clk;

  vls_addr_gen dut_i (
    .clk(clk), .rst(rst), .start_i(start), .mode_i(mode), .base_i(base),
    .imm_i(imm), .opw_i(opw), .ew_i(ew), .idx_signed_i(sgn),
    .idx_vbase_i(vbase), .soff_i(soff), .vl_i(vl),
    .off_valid_i(off_valid), .off_data_i(off_data), .off_ready_o(off_ready),
    .addr_valid_o(addr_valid), .addr_ready_i(addr_ready), .addr_o(addr),
    .done_o(done)
  );

  int checks = 0;
  int fails  = 0;
  logic [63:0] exp_q [$];
  logic [63:0] off_mem [16];
  int   off_n = 0;
  int   off_ptr = 0;
  int   seen = 0;
  logic run_idx = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic held = 1'b0;
  logic [63:0] held_addr = '0;
  int   cyc = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] xt(input logic [63:0] v, input logic [1:0] w, input bit s);
    case (w)
      2'd0:    xt = s ? {{56{v[7]}},  v[7:0]}  : {56'd0, v[7:0]};
      2'd1:    xt = s ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
      2'd2:    xt = s ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
      default: xt = v;
    endcase
  endfunction

  // Driver of ready, stream elements and monitor, all on the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (held) begin
        chk(addr_valid == 1'b1, "R7 valid held", {63'd0, addr_valid}, 64'd1);
        chk(addr == held_addr, "R7 addr held", addr, held_addr);
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      addr_ready = lfsr[0] | lfsr[3];
      off_valid  = run_idx && (off_ptr < off_n) && (lfsr[5] | lfsr[7]);
      off_data   = off_valid ? off_mem[off_ptr] : 64'hDEAD_BEEF_DEAD_BEEF;
      #1;
      if (!run_idx && off_ready)
        chk(1'b0, "R11 off_ready in strided mode", 64'd1, 64'd0);
      if (off_valid && off_ready) off_ptr++;
      held = addr_valid && !addr_ready;
      held_addr = addr;
      if (addr_valid && addr_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 extra address", addr, 64'd0);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          chk(addr == e, "R2/R3/R4/R5/R6/R10 address", addr, e);
        end
        seen++;
        if (run_idx)
          chk(seen <= off_ptr, "R11 address before element", 64'(seen), 64'(off_ptr));
      end
    end
  end

  task automatic run(input logic [1:0] m, input logic [63:0] b, input logic [15:0] im,
                     input logic [1:0] ow, input logic [1:0] w, input bit s, input bit vb,
                     input logic [63:0] so, input logic [7:0] n, input string tag);
    logic [63:0] ix;
    int guard;
    ix = {{48{im[15]}}, im};
    for (int i = 0; i < n; i++) begin
      case (m)
        2'd1:    exp_q.push_back(b + ix * 64'(i));
        2'd0:    exp_q.push_back(b + ix + (64'd1 << ow) * 64'(i));
        default: exp_q.push_back(vb ? off_mem[i] + xt(so, w, s) : b + xt(off_mem[i], w, s));
      endcase
    end
    @(negedge clk);
    start = 1'b1; mode = m; base = b; imm = im; opw = ow; ew = w; sgn = s;
    vbase = vb; soff = so; vl = n;
    off_ptr = 0; off_n = (m == 2'd2) ? int'(n) : 0; seen = 0;
    run_idx = (m == 2'd2);
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
    #2;
    chk(done == 1'b1, {"R8 done ", tag}, {63'd0, done}, 64'd1);
    chk(exp_q.size() == 0, {"R8 all addresses ", tag}, 64'(exp_q.size()), 64'd0);
    chk(seen == int'(n), {"R8 count ", tag}, 64'(seen), 64'(n));
    chk(addr_valid == 1'b0, {"R8 valid low at done ", tag}, {63'd0, addr_valid}, 64'd0);
    exp_q.delete();
    run_idx = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(addr_valid == 1'b0, "R1 valid", {63'd0, addr_valid}, 64'd0);
    chk(done == 1'b0, "R1 done", {63'd0, done}, 64'd0);
    chk(off_ready == 1'b0, "R1 off_ready", {63'd0, off_ready}, 64'd0);
    rst = 1'b0;
    @(negedge clk);

    run(2'd1, 64'h1000, 16'd24, 2'd0, 2'd0, 0, 0, 0, 8'd6, "R2 positive");
    run(2'd1, 64'h1000, 16'hFFF8, 2'd0, 2'd0, 0, 0, 0, 8'd5, "R2 negative");
    run(2'd0, 64'h2000, 16'd4, 2'd3, 2'd0, 0, 0, 0, 8'd4, "R3 width8");
    run(2'd0, 64'h2000, 16'hFFFE, 2'd1, 2'd0, 0, 0, 0, 8'd7, "R3 width2");
    run(2'd0, 64'h2001, 16'd0, 2'd0, 2'd0, 0, 0, 0, 8'd3, "R3 width1");
    run(2'd0, 64'hFFFF_FFFF_FFFF_FFF0, 16'd0, 2'd3, 2'd0, 0, 0, 0, 8'd5, "R10 wrap");

    for (int i = 0; i < 16; i++)
      off_mem[i] = {32'h8000_0000 | 32'(i * 7), 8'h00, 8'(i * 37), 8'hF0 ^ 8'(i), 8'h80 + 8'(i)};
    run(2'd2, 64'h4000, 0, 0, 2'd0, 1, 0, 0, 8'd8, "R4 R6 ew8 signed");
    run(2'd2, 64'h4000, 0, 0, 2'd0, 0, 0, 0, 8'd8, "R4 R6 ew8 unsigned");
    run(2'd2, 64'h4000, 0, 0, 2'd1, 0, 0, 0, 8'd6, "R6 ew16 unsigned");
    run(2'd2, 64'h0, 0, 0, 2'd2, 1, 0, 0, 8'd6, "R6 ew32 signed R10");
    run(2'd2, 64'h10, 0, 0, 2'd3, 1, 0, 0, 8'd5, "R6 ew64");
    run(2'd2, 64'h9999, 0, 0, 2'd0, 1, 1, 64'h0000_0000_0000_01FC, 8'd6, "R5 base vector");
    run(2'd2, 64'h9999, 0, 0, 2'd1, 0, 1, 64'hFFFF_FFFF_FFFF_8001, 8'd4, "R5 R6 unsigned");

    run(2'd1, 64'h1234, 16'd8, 2'd0, 2'd0, 0, 0, 0, 8'd0, "R9 zero vl strided");
    run(2'd2, 64'h1234, 16'd8, 2'd0, 2'd0, 0, 0, 0, 8'd0, "R9 zero vl indexed");
    run(2'd1, 64'h500, 16'd1, 2'd0, 2'd0, 0, 0, 0, 8'd40, "R8 long run");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 100000);
    fails++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=<100000 cycles", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule